// File: doc/BRIEF.md
# Watchdog and Interval Timer with Reset-Cause Flag

This block is an 8-bit up-counter clocked through a prescaler. It acts either as a periodic interval timer or as a watchdog. The prescaler is one free-running 12-bit divider. A 3-bit select picks one of eight unevenly spaced division ratios of the peripheral clock: 2, 32, 64, 128, 256, 512, 2048 or 4096. On each rising transition of the selected divider bit, the counter advances by one. The whole block therefore runs in the single clock domain. When the counter passes from 0xFF back to 0x00, an overflow has occurred.

In interval mode, an overflow raises a latched status flag, and that flag drives the interrupt output. In watchdog mode, an overflow does one of two things. It either pulses a non-maskable interrupt request for one clock, or it drives an internal reset output for a fixed 518 cycles. The block also keeps a read-only flag that tells software what caused the last reset. An external reset sets the flag to 1. A watchdog reset clears it to 0. The internal reset does not reinitialise the timer itself. Only the external reset input does that.

Software reaches the block through a two-register bus. Address 0 is control/status and address 1 is the counter. Writes take effect on the clock edge. Reads are combinational.

Top module: `wdt_core`

## Requirements
- R1: After the external reset, the control register reads 0x08 and the counter reads 0x00, and the interrupt, NMI and internal reset outputs are low. Control bit layout: bit7 overflow flag, bit6 mode (1 = watchdog), bit5 enable, bit4 action select (1 = internal reset, 0 = NMI), bit3 reset-cause flag, bits2:0 clock select.
- R2: Clock select codes 0 to 7 divide the peripheral clock by 2, 32, 64, 128, 256, 512, 2048 and 4096. The counter first advances D/2 clock edges after the enabling edge, then advances every D edges.
- R3: While the enable bit is 0, the counter and prescaler are held at zero, and writes to the counter are ignored.
- R4: A counter write while enabled loads the written value on that edge, and the load takes priority over a prescaler tick.
- R5: An overflow sets the overflow flag. The interrupt output is high exactly while the flag is set and the mode bit is 0.
- R6: The flag clears only when a control write with bit7 = 0 follows a read of the control register that returned bit7 = 1. Writing bit7 = 1 never sets the flag.
- R7: In watchdog mode with action select 0, an overflow drives the NMI output high for exactly one clock. The reset-cause flag and the internal reset output are unaffected.
- R8: In watchdog mode with action select 1, an overflow drives the internal reset output high for 518 clock cycles, beginning the cycle after the overflow edge, and clears the reset-cause flag to 0.
- R9: The internal reset leaves the control bits and counter running. Only the external reset returns the reset-cause flag to 1.
- R10: Writes to the reset-cause flag have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 1 | 0 = control/status, 1 = counter |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ovf_irq | output | 1 | Interval overflow interrupt, level |
| nmi_req | output | 1 | One-cycle NMI request pulse |
| sys_rst_out | output | 1 | Internal reset request, 518 cycles |

## Verification
The pulse-length check on the internal reset assumes that no second watchdog-reset overflow arrives while a pulse is still running. Such an overflow would restart the pulse. The checks on the NMI and on the reset-cause flag assume that the external reset is the only thing driving the block back to its initial state. The stimulus respects both assumptions. After every observed overflow, it reads the control register and writes it back with the timer disabled. Even at the fastest division used in the watchdog runs, that happens long before the counter could wrap a second time. Every counter preload is set close to 0xFF, so that even the slowest tap overflows within a few thousand cycles.

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W   = 8,
  parameter int PRE_W   = 12,
  parameter int RST_LEN = 518
) (
  input  logic       clk,
  input  logic       ext_rst_n,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       ovf_irq,
  output logic       nmi_req,
  output logic       sys_rst_out
);

  localparam int RW = $clog2(RST_LEN + 1);
  localparam int TW = $clog2(PRE_W);

  logic             ovf_q, wd_q, en_q, rsel_q, src_q, arm_q, nmi_q;
  logic [2:0]       cks_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [RW-1:0]    rcnt_q;

  function automatic logic [TW-1:0] tap_of(input logic [2:0] c);
    case (c)
      3'd0:    return TW'(0);
      3'd1:    return TW'(4);
      3'd2:    return TW'(5);
      3'd3:    return TW'(6);
      3'd4:    return TW'(7);
      3'd5:    return TW'(8);
      3'd6:    return TW'(10);
      default: return TW'(11);
    endcase
  endfunction

  logic [PRE_W-1:0] tap_mask;
  logic             tick, ctrl_wr, cnt_wr, ovf_evt, wd_rst, wd_nmi;

  assign tap_mask = (PRE_W'(1) << (tap_of(cks_q) + TW'(1))) - PRE_W'(1);
  assign tick     = en_q && ((pre_q & tap_mask) == (tap_mask >> 1));
  assign ctrl_wr  = bus_wr && !bus_addr;
  assign cnt_wr   = bus_wr && bus_addr && en_q;
  assign ovf_evt  = tick && !cnt_wr && (cnt_q == {CNT_W{1'b1}});
  assign wd_rst   = ovf_evt && wd_q && rsel_q;
  assign wd_nmi   = ovf_evt && wd_q && !rsel_q;

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (!en_q) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
      if (cnt_wr)    cnt_q <= bus_wdata[CNT_W-1:0];
      else if (tick) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      wd_q   <= 1'b0;
      en_q   <= 1'b0;
      rsel_q <= 1'b0;
      cks_q  <= 3'd0;
    end else if (ctrl_wr) begin
      wd_q   <= bus_wdata[6];
      en_q   <= bus_wdata[5];
      rsel_q <= bus_wdata[4];
      cks_q  <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      ovf_q <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (ovf_evt)                              ovf_q <= 1'b1;
      else if (ctrl_wr && arm_q && !bus_wdata[7]) ovf_q <= 1'b0;
      if (ctrl_wr)                              arm_q <= 1'b0;
      else if (bus_rd && !bus_addr && ovf_q)    arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge ext_rst_n) begin
    if (!ext_rst_n) begin
      src_q  <= 1'b1;
      rcnt_q <= '0;
      nmi_q  <= 1'b0;
    end else begin
      nmi_q <= wd_nmi;
      if (wd_rst) begin
        src_q  <= 1'b0;
        rcnt_q <= RW'(RST_LEN);
      end else if (rcnt_q != '0) begin
        rcnt_q <= rcnt_q - RW'(1);
      end
    end
  end

  assign ovf_irq     = ovf_q && !wd_q;
  assign nmi_req     = nmi_q;
  assign sys_rst_out = (rcnt_q != '0);
  assign bus_rdata   = bus_addr ? 8'(cnt_q)
                                : {ovf_q, wd_q, en_q, rsel_q, src_q, cks_q};

endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
  parameter int CNT_W   = 8,
  parameter int RST_LEN = 518
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CNT_W-1:0] cnt,
  input logic             ovf,
  input logic             wd,
  input logic             src,
  input logic             nmi,
  input logic             sys_rst
);

  logic [15:0] hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_cnt <= '0;
    else if (sys_rst) hi_cnt <= hi_cnt + 16'd1;
    else              hi_cnt <= '0;
  end

  AST_DISABLED_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0));  // R3
  AST_FLAG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(en));  // R5
  AST_NMI_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi);  // R7
  AST_NMI_FROM_WATCHDOG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |-> $past(wd));  // R7
  AST_NMI_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> !$rose(sys_rst));  // R7
  AST_RESET_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst) |-> (hi_cnt == 16'(RST_LEN)));  // R8
  AST_RESET_CLEARS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> !src);  // R8
  AST_SRC_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !src |=> !src);  // R10

endmodule

bind wdt_core wdt_core_chk #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(ext_rst_n), .en(en_q), .cnt(cnt_q), .ovf(ovf_q),
  .wd(wd_q), .src(src_q), .nmi(nmi_req), .sys_rst(sys_rst_out)
);

// File: tb/wdt_core_tb_top.sv
module wdt_core_tb_top;

  logic       clk = 1'b0;
  logic       ext_rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       ovf_irq, nmi_req, sys_rst_out;

  wdt_core dut_i (
    .clk(clk), .ext_rst_n(ext_rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ovf_irq(ovf_irq), .nmi_req(nmi_req), .sys_rst_out(sys_rst_out)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef enum int {EV_IRQ, EV_NMI, EV_RST_ON, EV_RST_OFF} ev_kind_e;
  typedef struct { ev_kind_e kind; int at; string req; } ev_t;
  ev_t sb_q[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_ev(input ev_kind_e k, input int at, input string req);
    ev_t e;
    e.kind = k; e.at = at; e.req = req;
    sb_q.push_back(e);
  endtask

  logic p_irq = 0, p_nmi = 0, p_rst = 0;
  always @(negedge clk) begin
    if (ext_rst_n) begin
      if (ovf_irq && !p_irq)     take(EV_IRQ);
      if (nmi_req && !p_nmi)     take(EV_NMI);
      if (sys_rst_out && !p_rst) take(EV_RST_ON);
      if (!sys_rst_out && p_rst) take(EV_RST_OFF);
    end
    p_irq = ovf_irq; p_nmi = nmi_req; p_rst = sys_rst_out;
  end

  task automatic take(input ev_kind_e k);
    ev_t e;
    if (sb_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL unexpected event: actual kind %0d at %0d expected none", k, cyc);
    end else begin
      e = sb_q.pop_front();
      chk(e.req, "event kind", int'(k), int'(e.kind));
      chk(e.req, "event cycle", cyc, e.at);
    end
  endtask

  int t0;
  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    t0 = cyc;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(posedge clk);
    #1 bus_rd = 1'b0;
  endtask

  task automatic peek(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  task automatic ext_reset();
    @(negedge clk);
    ext_rst_n = 1'b0;
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending events expected 0", sb_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] v;
    int div;
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b1;

    // R1: reset state
    peek(1'b0, v); chk("R1", "ctrl after reset", v, 8'h08);
    peek(1'b1, v); chk("R1", "counter after reset", v, 8'h00);
    chk("R1", "outputs after reset", {ovf_irq, nmi_req, sys_rst_out}, 0);

    // R3: counter writes ignored while disabled
    wr(1'b1, 8'h55);
    repeat (4) @(negedge clk);
    peek(1'b1, v); chk("R3", "counter write while disabled", v, 8'h00);

    // R2 R5: divide-by-2 from zero, 256 ticks, overflow at 1 + 255*2 edges
    wr(1'b0, 8'h20);
    expect_ev(EV_IRQ, t0 + 511, "R2 R5 div2");
    drain();
    peek(1'b0, v); chk("R5", "flag set in interval mode", v, 8'hA8);
    chk("R5", "irq level", ovf_irq, 1);

    // R6: clear protocol
    wr(1'b0, 8'h20);
    peek(1'b0, v); chk("R6", "write 0 without read keeps flag", v, 8'hA8);
    chk("R6", "irq held", ovf_irq, 1);
    rd(1'b0, v); chk("R6", "arming read", v, 8'hA8);
    wr(1'b0, 8'h00);
    peek(1'b0, v); chk("R6", "flag cleared after read then write 0", v, 8'h08);
    chk("R6", "irq cleared", ovf_irq, 0);
    wr(1'b0, 8'h80);
    peek(1'b0, v); chk("R6", "writing 1 does not set flag", v, 8'h08);
    peek(1'b1, v); chk("R3", "counter zero when disabled", v, 8'h00);

    // R2 R4: remaining taps with preload 253, overflow at 5*D/2 edges
    for (int code = 1; code < 8; code++) begin
      case (code)
        1: div = 32;   2: div = 64;   3: div = 128;  4: div = 256;
        5: div = 512;  6: div = 2048; default: div = 4096;
      endcase
      wr(1'b0, 8'h20 | 8'(code));
      expect_ev(EV_IRQ, t0 + 5 * div / 2, "R2 tap");
      wr(1'b1, 8'd253);
      peek(1'b1, v); chk("R4", "counter load", v, 8'd253);
      drain();
      rd(1'b0, v); chk("R5", "ctrl after tap overflow", v, 8'hA8 | 8'(code));
      wr(1'b0, 8'h00);
      peek(1'b0, v); chk("R6", "cleared after tap run", v, 8'h08);
    end

    // R7: watchdog mode, NMI action
    wr(1'b0, 8'h61);
    expect_ev(EV_NMI, t0 + 80, "R7 nmi");
    wr(1'b1, 8'd253);
    drain();
    repeat (2) @(negedge clk);
    peek(1'b0, v); chk("R7", "ctrl after nmi, cause kept", v, 8'hE9);
    chk("R5", "no irq in watchdog mode", ovf_irq, 0);
    chk("R7", "no internal reset", sys_rst_out, 0);
    rd(1'b0, v);
    wr(1'b0, 8'h00);

    // R8 R9: watchdog mode, internal reset action
    wr(1'b0, 8'h71);
    expect_ev(EV_RST_ON, t0 + 80, "R8 reset start");
    expect_ev(EV_RST_OFF, t0 + 80 + 518, "R8 reset length");
    wr(1'b1, 8'd253);
    while (!sys_rst_out) @(negedge clk);
    peek(1'b0, v); chk("R8", "cause cleared by watchdog reset", v, 8'hF1);
    drain();
    peek(1'b0, v); chk("R9", "ctrl retained over internal reset", v, 8'hF1);
    peek(1'b1, v); chk("R9", "counter kept running", v, 8'd16);

    // R10: cause flag not writable
    rd(1'b0, v);
    wr(1'b0, 8'h08);
    peek(1'b0, v); chk("R10", "write to cause flag ignored", v, 8'h00);

    // R9: external reset restores cause flag
    ext_reset();
    peek(1'b0, v); chk("R9", "cause set by external reset", v, 8'h08);

    repeat (4) @(negedge clk);
    done = 1;
    finish_run();
  end

endmodule